// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

This block gathers message-signalled interrupts for 256 vectors and presents them to the host as one level interrupt line. An endpoint raises a vector by writing its number to a single doorbell address. The write latches a pending flag for that vector. The flag stays set until software acknowledges it.

Each vector also has its own enable flag. The host line is high while at least one vector is both pending and enabled. Software reads pending state through eight banked 32-bit words and acknowledges vectors by writing ones to them. It sets or clears enable flags by reading and rewriting the matching enable word. Access is through a simple memory-mapped port: a single-cycle write strobe, and a read whose data is returned in the cycle after the request.

Top module: `msi_collector`

## Requirements
- R1: After reset, every pending flag and every enable flag is zero, `irq_o` is low, and all status and enable words read back as 0.
- R2: A write to byte offset 0x7C (the doorbell) with data value v, where v is below 256, sets the pending flag of vector v. Vector v maps to bit v%32 of status word v/32.
- R3: Status word k sits at offset 0x80 + 4*k, for k from 0 to 7. A read request in one cycle returns that word's contents on `rd_data_o` in the next cycle.
- R4: Writing a status word clears each pending flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: Enable word k sits at offset 0xA0 + 4*k and can be read and written in full. It uses the same vector-to-bit mapping as the status words.
- R6: `irq_o` is high in a cycle exactly when some vector's pending flag and enable flag are both 1. The line is registered and follows flag changes by one cycle.
- R7: A pending flag is set even while its vector is masked. Once its enable flag is set, it drives `irq_o` high.
- R8: If a doorbell raise and a status-word clear hit the same vector in the same cycle, the flag ends up set.
- R9: A doorbell value of 256 or more changes no pending flag.
- R10: A raised flag stays set until it is cleared through its status word. Further doorbell writes to the same vector leave it set.
- R11: Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data, valid in the cycle after the request |
| db_en_i | input | 1 | Extra doorbell raise, same cycle as a write |
| db_vec_i | input | 32 | Vector number for the extra doorbell raise |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
If a pending flag is corrupted, it shows up in the status word readback one cycle after the read request. If that vector is enabled, it also shows up on `irq_o` one cycle after the flag changes. Decoding the wrong bank or bit makes a raised vector appear in some other word. For that reason, the bench reads every bank after targeted raises. If the rule for a simultaneous set and clear is reversed, the bench sees a zero where it expects a one in the readback that follows the collision. A mishandled out-of-range doorbell shows up as a nonzero word in the status scan.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int unsigned NUM_VEC   = 256;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_BANK  = NUM_VEC / WORD_W;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned BANK_W    = $clog2(NUM_BANK);
    localparam int unsigned BIT_W     = $clog2(WORD_W);
    localparam logic [ADDR_W-1:0] DOORBELL_OFS = 8'h7C;
    localparam logic [ADDR_W-1:0] STATUS_OFS   = 8'h80;
    localparam logic [ADDR_W-1:0] ENABLE_OFS   = 8'hA0;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_DOORBELL,
        REG_STATUS,
        REG_ENABLE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e            kind;
        logic [BANK_W-1:0]    bank;
    } reg_sel_t;
endpackage

// File: rtl/msi_addr_decode.sv
// Address decoder: maps a byte offset to a register kind and bank index.
// Assumes word-aligned offsets; misaligned offsets decode as REG_NONE.
module msi_addr_decode
    import msi_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int unsigned SPAN = NUM_BANK * 4;

    logic [ADDR_W-1:0] st_rel;
    logic [ADDR_W-1:0] en_rel;

    // Offsets relative to each bank array base.
    always_comb begin
        st_rel = addr_i - STATUS_OFS;
        en_rel = addr_i - ENABLE_OFS;
    end

    // Classify the offset.
    always_comb begin
        sel_o.kind = REG_NONE;
        sel_o.bank = '0;
        if (addr_i == DOORBELL_OFS) begin
            sel_o.kind = REG_DOORBELL;
        end else if (addr_i >= STATUS_OFS && 32'(st_rel) < SPAN && st_rel[1:0] == 2'b00) begin
            sel_o.kind = REG_STATUS;
            sel_o.bank = st_rel[BANK_W+1:2];
        end else if (addr_i >= ENABLE_OFS && 32'(en_rel) < SPAN && en_rel[1:0] == 2'b00) begin
            sel_o.kind = REG_ENABLE;
            sel_o.bank = en_rel[BANK_W+1:2];
        end
    end
endmodule

// File: rtl/msi_bank.sv
// One bank of 32 vectors: pending flags (set by doorbell, write-one-to-clear)
// and enable flags (plain read/write). Set takes priority over clear.
// Assumes at most one register write per cycle.
module msi_bank
    import msi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] set_i,
    input  logic              clr_en_i,
    input  logic [WORD_W-1:0] clr_data_i,
    input  logic              en_we_i,
    input  logic [WORD_W-1:0] en_data_i,
    output logic [WORD_W-1:0] pend_o,
    output logic [WORD_W-1:0] en_o,
    output logic              act_o
);
    logic [WORD_W-1:0] pend_q;
    logic [WORD_W-1:0] en_q;
    logic [WORD_W-1:0] clr_mask;

    // Clear mask is only live during a status write.
    always_comb clr_mask = clr_en_i ? clr_data_i : '0;

    // Pending flags: keep, clear on write-one, set on doorbell (set wins).
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= (pend_q & ~clr_mask) | set_i;
    end

    // Enable flags: full-word write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      en_q <= '0;
        else if (en_we_i) en_q <= en_data_i;
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign act_o  = |(pend_q & en_q);

    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
    // R4
    clear_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i == '0 && !clr_en_i) |=> $stable(pend_q));
    // R10
    no_spurious_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_en_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/msi_collector.sv
// Top level: doorbell vector decode, NUM_BANK vector banks, registered
// read port and registered combined interrupt line.
// Assumes one write and one read per cycle at most; read data has one cycle latency.
module msi_collector
    import msi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              db_en_i,
    input  logic [WORD_W-1:0] db_vec_i,
    output logic              irq_o
);
    reg_sel_t wsel;
    reg_sel_t rsel;

    logic [NUM_BANK-1:0][WORD_W-1:0] pend_w;
    logic [NUM_BANK-1:0][WORD_W-1:0] en_w;
    logic [NUM_BANK-1:0]             act_w;
    logic [NUM_VEC-1:0]              set_vec;
    logic [WORD_W-1:0]               rd_q;
    logic [WORD_W-1:0]               rd_next;
    logic                            irq_q;

    msi_addr_decode i_wdec (.addr_i(wr_addr_i), .sel_o(wsel));
    msi_addr_decode i_rdec (.addr_i(rd_addr_i), .sel_o(rsel));

    // One-hot set vector from the bus doorbell and the side doorbell.
    always_comb begin
        set_vec = '0;
        if (wr_en_i && wsel.kind == REG_DOORBELL && wr_data_i < WORD_W'(NUM_VEC))
            set_vec[wr_data_i[BANK_W+BIT_W-1:0]] = 1'b1;
        if (db_en_i && db_vec_i < WORD_W'(NUM_VEC))
            set_vec[db_vec_i[BANK_W+BIT_W-1:0]] = 1'b1;
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        msi_bank i_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .set_i      (set_vec[b*WORD_W +: WORD_W]),
            .clr_en_i   (wr_en_i && wsel.kind == REG_STATUS && wsel.bank == BANK_W'(b)),
            .clr_data_i (wr_data_i),
            .en_we_i    (wr_en_i && wsel.kind == REG_ENABLE && wsel.bank == BANK_W'(b)),
            .en_data_i  (wr_data_i),
            .pend_o     (pend_w[b]),
            .en_o       (en_w[b]),
            .act_o      (act_w[b])
        );
    end

    // Read mux for the selected word.
    always_comb begin
        case (rsel.kind)
            REG_STATUS: rd_next = pend_w[rsel.bank];
            REG_ENABLE: rd_next = en_w[rsel.bank];
            default:    rd_next = '0;
        endcase
    end

    // Read data register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_next;
    end

    // Combined interrupt register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= |act_w;
    end

    assign rd_data_o = rd_q;
    assign irq_o     = irq_q;

    // R6
    irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|act_w) |=> irq_o);
    // R6
    irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|act_w) |=> !irq_o);
    // R9
    oob_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!db_en_i && wr_en_i && wsel.kind == REG_DOORBELL && wr_data_i >= WORD_W'(NUM_VEC))
        |-> (set_vec == '0));
    // R2
    one_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(set_vec) <= 2);
endmodule

// File: tb/test_msi_collector.sv
module test_msi_collector;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        db_en = 1'b0;
    logic [31:0] db_vec = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_collector i_msi_collector (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .db_en_i(db_en), .db_vec_i(db_vec), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after falling edge, hold across one rising edge.
    task automatic write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 8; k++) begin
            write(8'h80 + 8'(4*k), 32'hFFFF_FFFF);
            write(8'hA0 + 8'(4*k), 32'h0);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            read(8'h80 + 8'(4*k), d); check("R1 status", d, 0);
            read(8'hA0 + 8'(4*k), d); check("R1 enable", d, 0);
        end
    endtask

    task automatic t_doorbell_map();
        logic [31:0] d;
        int vecs[4] = '{0, 37, 200, 255};
        foreach (vecs[i]) begin
            clear_all();
            write(8'h7C, vecs[i]);
            for (int k = 0; k < 8; k++) begin
                read(8'h80 + 8'(4*k), d);
                check("R2 R3 map", d, (k == vecs[i]/32) ? (32'h1 << (vecs[i]%32)) : 32'h0);
            end
        end
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        clear_all();
        write(8'h7C, 64); write(8'h7C, 65); write(8'h7C, 70);
        write(8'h88, 32'h0000_0002);
        read(8'h88, d); check("R4 w1c partial", d, 32'h0000_0041);
        write(8'h88, 32'h0);
        read(8'h88, d); check("R4 zero write", d, 32'h0000_0041);
    endtask

    task automatic t_enable_irq();
        logic [31:0] d;
        clear_all();
        write(8'hB4, 32'hA5A5_0F0F);
        read(8'hB4, d); check("R5 enable rw", d, 32'hA5A5_0F0F);
        read(8'hA0, d); check("R5 other bank", d, 32'h0);
        check("R6 no pending", {31'd0, irq}, 0);
        write(8'h7C, 160);  // bank 5 bit 0, enabled
        @(negedge clk); check("R6 irq high", {31'd0, irq}, 1);
        write(8'h94, 32'h1);
        @(negedge clk); check("R6 irq low after ack", {31'd0, irq}, 0);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        clear_all();
        write(8'h7C, 10);
        @(negedge clk); check("R7 masked irq", {31'd0, irq}, 0);
        read(8'h80, d); check("R7 latched", d, 32'h400);
        write(8'hA0, 32'h400);
        @(negedge clk); check("R7 irq after enable", {31'd0, irq}, 1);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        clear_all();
        write(8'h7C, 99);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h8C; wr_data = 32'h0000_0009;
        db_en = 1'b1; db_vec = 99;
        @(negedge clk);
        wr_en = 1'b0; db_en = 1'b0;
        read(8'h8C, d); check("R8 set wins", d, 32'h0000_0008);
    endtask

    task automatic t_oob();
        logic [31:0] d;
        logic [31:0] acc;
        clear_all();
        write(8'h7C, 256); write(8'h7C, 32'h8000_0003);
        acc = 0;
        for (int k = 0; k < 8; k++) begin read(8'h80 + 8'(4*k), d); acc |= d; end
        check("R9 out of range", acc, 0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        clear_all();
        write(8'h7C, 33);
        repeat (5) @(negedge clk);
        write(8'h7C, 33);
        read(8'h84, d); check("R10 sticky", d, 32'h2);
        read(8'h40, d); check("R11 unmapped", d, 0);
        read(8'h7C, d); check("R11 doorbell read", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_doorbell_map();
        t_w1c();
        t_enable_irq();
        t_masked();
        t_collision();
        t_oob();
        t_sticky();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule